// File: doc/BRIEF.md
# Power-Switch Command Register File

This block sits behind the serial shift stage of a protected high-side power switch controller. Each time the shift stage finishes an 8-bit command word it raises a one-cycle valid strobe. The block then decodes the 3-bit register field and updates one of four configuration registers. These registers hold the output on/off and sense-enable control, the over-current threshold codes, the fault-blanking and detection-disable settings, and the direct-pin control gate. Every stored field is driven out as a plain decoded signal for the protection logic.

Writing address zero changes no configuration. It only picks which register image goes into the next outgoing serial byte. The outgoing byte is kept registered, so it is stable well before the next word starts shifting. The top bit of an output-control word is not stored. It produces a one-cycle strobe that feeds an external watchdog. An output-control word with any reserved bit set is refused and flagged.

Top module: `pwr_cfg_regfile`

## Requirements
- R1: After a synchronous active-low reset, every configuration field, the readback selector, `rd_byte`, `cmd_err` and `wd_feed` are all zero.
- R2: A word is acted on only in a cycle where `word_valid` is 1. Words presented with `word_valid` at 0 change no output.
- R3: A valid word with bits 6:4 = 001 and bits 3:2 = 00 loads `out_on` from bit 0 and `sense_en` from bit 1, visible one cycle after the strobe.
- R4: A valid word with bits 6:4 = 001 and bit 2 or bit 3 set leaves `out_on` and `sense_en` unchanged and raises `cmd_err` for exactly one cycle, one cycle after the strobe. No other word raises `cmd_err`.
- R5: An accepted output-control word (see R3) with bit 7 = 1 raises `wd_feed` for exactly one cycle, one cycle after the strobe. Bit 7 of any other word, including a refused control word, has no effect.
- R6: A valid word with bits 6:4 = 010 loads `oc_low_code` from bits 2:0 and `oc_high_sel` from bit 3.
- R7: A valid word with bits 6:4 = 011 loads `blank_code` from bits 1:0, `oclo_timeout_dis` from bit 2 and `openload_dis` from bit 3.
- R8: A valid word with bits 6:4 = 100 loads `direct_in_block` from bit 1. Bits 0, 2 and 3 of that word are ignored.
- R9: A valid word with bits 6:4 = 000 loads the readback selector from bits 2:0 and changes no configuration output.
- R10: `rd_byte` is registered. One cycle after any clock it shows the image chosen by the selector as it stood after the previous clock. Every image is {0, sel[2:0], data[3:0]}. The data is: sel 0 gives {0, sel}; sel 1 gives {0, 0, sense_en, out_on}; sel 2 gives {oc_high_sel, oc_low_code}; sel 3 gives {openload_dis, oclo_timeout_dis, blank_code}; sel 4 gives {0, 0, direct_in_block, 0}; sel 5 to 7 give 0000.
- R11: Valid words with bits 6:4 in 101, 110 or 111 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | One-cycle strobe marking a complete command word |
| word_in | input | 8 | Command word from the shift stage |
| rd_byte | output | 8 | Registered readback image for the next outgoing word |
| out_on | output | 1 | Output switch command |
| sense_en | output | 1 | Current-sense output enable |
| oc_low_code | output | 3 | Over-current low threshold code |
| oc_high_sel | output | 1 | Over-current high threshold select |
| blank_code | output | 2 | Over-current low blanking-time code |
| oclo_timeout_dis | output | 1 | Disable the over-current low timeout |
| openload_dis | output | 1 | Disable open-load detection |
| direct_in_block | output | 1 | Block control of the output by the external input pin |
| wd_feed | output | 1 | One-cycle watchdog feed strobe |
| cmd_err | output | 1 | One-cycle flag for a refused output-control word |

## Verification
A configuration write and the readback refresh can land in the same cycle. The bench provokes this by first pointing the selector at a register and then writing that same register. The following `rd_byte` must then show the new contents, not the old ones. A control word with bit 7 set and a reserved bit set provokes the feed and reject paths together. The only correct result is an error pulse with no feed and no change to the output state. The bench drives a long run of random words, with valid gaps, reserved-bit violations and unused addresses. A behavioural model predicts every output and is compared against the design after every clock.

// File: rtl/pcfg_pkg.sv
// Package: shared widths, register addresses and the stored-configuration
// record of the power-switch command register file.
// Assumes one command word per valid strobe; no state is held here.
package pcfg_pkg;
    localparam int WORD_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 4;
    localparam int NREG    = 1 << ADDR_W;
    localparam int ADDR_LO = DATA_W;
    localparam int FEED_B  = WORD_W - 1;

    localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_THR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_TIME = 3'd3;
    localparam logic [ADDR_W-1:0] A_DIN  = 3'd4;

    typedef struct packed {
        logic              on;
        logic              sense;
        logic [2:0]        oc_low;
        logic              oc_high;
        logic [1:0]        blank;
        logic              cd_dis;
        logic              ol_dis;
        logic              din_block;
        logic [ADDR_W-1:0] sel;
    } cfg_t;
endpackage

// File: rtl/pcfg_decode.sv
// Module: command-word decoder. It splits a word into address, data and
// feed bit, and produces one raw write strobe per address.
// Assumes word_in is only meaningful while word_valid is high.
module pcfg_decode
    import pcfg_pkg::*;
(
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    output logic [NREG-1:0]   wr_raw,
    output logic [DATA_W-1:0] wdata,
    output logic              ctrl_bad,
    output logic              feed_bit
);
    logic [ADDR_W-1:0] addr;

    // split the word into its fields
    always_comb begin
        addr     = word_in[ADDR_LO +: ADDR_W];
        wdata    = word_in[DATA_W-1:0];
        feed_bit = word_in[FEED_B];
        ctrl_bad = word_in[3] | word_in[2];
    end

    // one write strobe per register address
    for (genvar g = 0; g < NREG; g++) begin : g_wr
        assign wr_raw[g] = word_valid && (addr == ADDR_W'(g));
    end
endmodule

// File: rtl/pcfg_store.sv
// Module: configuration storage. It applies decoded writes, refuses control
// words that have reserved bits set, and times the error and feed strobes.
// Assumes at most one write strobe is active per cycle (one-hot from decode).
module pcfg_store
    import pcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   wr_raw,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ctrl_bad,
    input  logic              feed_bit,
    output cfg_t              cfg,
    output logic              cmd_err,
    output logic              wd_feed
);
    logic ctrl_ok;
    assign ctrl_ok = wr_raw[A_CTRL] && !ctrl_bad;

    // register update for every configuration field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (wr_raw[A_STAT]) cfg.sel <= wdata[ADDR_W-1:0];
            if (ctrl_ok) begin
                cfg.on    <= wdata[0];
                cfg.sense <= wdata[1];
            end
            if (wr_raw[A_THR]) begin
                cfg.oc_low  <= wdata[2:0];
                cfg.oc_high <= wdata[3];
            end
            if (wr_raw[A_TIME]) begin
                cfg.blank  <= wdata[1:0];
                cfg.cd_dis <= wdata[2];
                cfg.ol_dis <= wdata[3];
            end
            if (wr_raw[A_DIN]) cfg.din_block <= wdata[1];
        end
    end

    // one-cycle error and feed strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_err <= 1'b0;
            wd_feed <= 1'b0;
        end else begin
            cmd_err <= wr_raw[A_CTRL] && ctrl_bad;
            wd_feed <= ctrl_ok && feed_bit;
        end
    end

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_raw) == '0) |-> $stable(cfg));
    assert_refused_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_raw[A_CTRL] && ctrl_bad)) |-> ($stable(cfg.on) && $stable(cfg.sense)));
    assert_err_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(wr_raw[A_CTRL] && ctrl_bad));
    assert_feed_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wd_feed |-> ($past(wr_raw[A_CTRL]) && $past(feed_bit) && !$past(ctrl_bad)));
    assert_status_no_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_raw[A_STAT])) |-> ($stable(cfg.on) && $stable(cfg.oc_low) && $stable(cfg.blank) && $stable(cfg.din_block)));
endmodule

// File: rtl/pcfg_readback.sv
// Module: readback image selector. Every clock it registers the image of the
// register chosen by the selector, so the byte is settled long before the
// next serial word starts. Assumes cfg comes straight from pcfg_store.
module pcfg_readback
    import pcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    output logic [WORD_W-1:0] rd_byte
);
    logic [DATA_W-1:0] img;

    // pick the data nibble for the selected register
    always_comb begin
        unique case (cfg.sel)
            A_STAT:  img = {1'b0, cfg.sel};
            A_CTRL:  img = {2'b00, cfg.sense, cfg.on};
            A_THR:   img = {cfg.oc_high, cfg.oc_low};
            A_TIME:  img = {cfg.ol_dis, cfg.cd_dis, cfg.blank};
            A_DIN:   img = {2'b00, cfg.din_block, 1'b0};
            default: img = '0;
        endcase
    end

    // register the outgoing byte
    always_ff @(posedge clk) begin
        if (!rst_n) rd_byte <= '0;
        else        rd_byte <= {1'b0, cfg.sel, img};
    end

    assert_rd_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rd_byte[ADDR_LO +: ADDR_W] == $past(cfg.sel) && !rd_byte[FEED_B]));
endmodule

// File: rtl/pwr_cfg_regfile.sv
// Module: top of the power-switch command register file. It connects the
// decoder, the storage and the readback stage, and exposes each field.
// Assumes word_valid is a one-cycle strobe from an external shift stage.
module pwr_cfg_regfile
    import pcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] rd_byte,
    output logic              out_on,
    output logic              sense_en,
    output logic [2:0]        oc_low_code,
    output logic              oc_high_sel,
    output logic [1:0]        blank_code,
    output logic              oclo_timeout_dis,
    output logic              openload_dis,
    output logic              direct_in_block,
    output logic              wd_feed,
    output logic              cmd_err
);
    logic [NREG-1:0]   wr_raw;
    logic [DATA_W-1:0] wdata;
    logic              ctrl_bad;
    logic              feed_bit;
    cfg_t              cfg;

    pcfg_decode u_dec (
        .word_valid (word_valid),
        .word_in    (word_in),
        .wr_raw     (wr_raw),
        .wdata      (wdata),
        .ctrl_bad   (ctrl_bad),
        .feed_bit   (feed_bit)
    );

    pcfg_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_raw   (wr_raw),
        .wdata    (wdata),
        .ctrl_bad (ctrl_bad),
        .feed_bit (feed_bit),
        .cfg      (cfg),
        .cmd_err  (cmd_err),
        .wd_feed  (wd_feed)
    );

    pcfg_readback u_rb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .rd_byte (rd_byte)
    );

    // expose the stored fields
    always_comb begin
        out_on           = cfg.on;
        sense_en         = cfg.sense;
        oc_low_code      = cfg.oc_low;
        oc_high_sel      = cfg.oc_high;
        blank_code       = cfg.blank;
        oclo_timeout_dis = cfg.cd_dis;
        openload_dis     = cfg.ol_dis;
        direct_in_block  = cfg.din_block;
    end

    assert_unused_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(word_valid) && $past(word_in[6])
         && $past(word_in[5:4]) != 2'b00) |-> $stable(cfg));
    assert_reset_clear_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (cfg == '0 && !cmd_err && !wd_feed));
endmodule

// File: tb/sim_pwr_cfg_regfile.sv
// Bench: behavioural model of the register file, compared on every clock,
// plus directed corner cases and random command traffic.
module sim_pwr_cfg_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       word_valid = 1'b0;
    logic [7:0] word_in = 8'h00;
    logic [7:0] rd_byte;
    logic       out_on, sense_en, oc_high_sel, oclo_timeout_dis, openload_dis;
    logic       direct_in_block, wd_feed, cmd_err;
    logic [2:0] oc_low_code;
    logic [1:0] blank_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_cfg_regfile u0 (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
        .rd_byte(rd_byte), .out_on(out_on), .sense_en(sense_en),
        .oc_low_code(oc_low_code), .oc_high_sel(oc_high_sel),
        .blank_code(blank_code), .oclo_timeout_dis(oclo_timeout_dis),
        .openload_dis(openload_dis), .direct_in_block(direct_in_block),
        .wd_feed(wd_feed), .cmd_err(cmd_err)
    );

    // reference model state
    int m_on, m_sense, m_low, m_high, m_blank, m_cd, m_ol, m_blk, m_sel;
    int m_err, m_feed, m_rd;

    function automatic int image();
        int d;
        case (m_sel)
            0: d = m_sel;
            1: d = m_sense * 2 + m_on;
            2: d = m_high * 8 + m_low;
            3: d = m_ol * 8 + m_cd * 4 + m_blank;
            4: d = m_blk * 2;
            default: d = 0;
        endcase
        return m_sel * 16 + d;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_on = 0; m_sense = 0; m_low = 0; m_high = 0; m_blank = 0;
            m_cd = 0; m_ol = 0; m_blk = 0; m_sel = 0; m_err = 0; m_feed = 0; m_rd = 0;
        end else begin
            int a, d, nrd;
            nrd = image();
            a = int'(word_in[6:4]);
            d = int'(word_in[3:0]);
            m_err = 0;
            m_feed = 0;
            if (word_valid) begin
                case (a)
                    0: m_sel = d % 8;
                    1: if (d >= 4) m_err = 1;
                       else begin
                           m_on = d % 2; m_sense = d / 2;
                           m_feed = int'(word_in[7]);
                       end
                    2: begin m_low = d % 8; m_high = d / 8; end
                    3: begin m_blank = d % 4; m_cd = (d / 4) % 2; m_ol = d / 8; end
                    4: m_blk = (d / 2) % 2;
                    default: ;
                endcase
            end
            m_rd = nrd;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(int'(out_on) == m_on && int'(sense_en) == m_sense, "R3",
            {sense_en, out_on}, m_sense * 2 + m_on);
        chk(int'(cmd_err) == m_err, "R4", cmd_err, m_err);
        chk(int'(wd_feed) == m_feed, "R5", wd_feed, m_feed);
        chk(int'(oc_low_code) == m_low && int'(oc_high_sel) == m_high, "R6",
            {oc_high_sel, oc_low_code}, m_high * 8 + m_low);
        chk(int'(blank_code) == m_blank && int'(oclo_timeout_dis) == m_cd
            && int'(openload_dis) == m_ol, "R7",
            {openload_dis, oclo_timeout_dis, blank_code}, m_ol * 8 + m_cd * 4 + m_blank);
        chk(int'(direct_in_block) == m_blk, "R8", direct_in_block, m_blk);
        chk(int'(rd_byte) == m_rd, "R10", rd_byte, m_rd);
    endtask

    // compare after the last edge, then drive the next word
    task automatic step(input bit v, input logic [7:0] w);
        @(negedge clk);
        if (rst_n) compare_all();
        word_valid = v;
        word_in = w;
    endtask

    task automatic idle();
        step(1'b0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1: everything cleared by reset
        chk({rd_byte, out_on, sense_en, oc_low_code, oc_high_sel, blank_code,
             oclo_timeout_dis, openload_dis, direct_in_block, wd_feed, cmd_err} == '0,
            "R1", rd_byte, 0);
        // R2: words without the strobe are ignored
        step(1'b0, 8'h13);
        step(1'b0, 8'h2F);
        idle();
        chk(out_on == 1'b0 && oc_low_code == 3'd0, "R2", {out_on, oc_low_code}, 0);
        // R3 and R5: accepted control word with feed bit
        step(1'b1, 8'h93);
        idle();
        chk(wd_feed == 1'b1 && out_on == 1'b1 && sense_en == 1'b1, "R5", {wd_feed, out_on}, 3);
        idle();
        chk(wd_feed == 1'b0, "R5", wd_feed, 0);
        // R4 with R5: refused word with feed bit set gives error, no feed
        step(1'b1, 8'h98);
        idle();
        chk(cmd_err == 1'b1 && wd_feed == 1'b0 && out_on == 1'b1, "R4",
            {cmd_err, wd_feed, out_on}, 5);
        idle();
        chk(cmd_err == 1'b0, "R4", cmd_err, 0);
        // R9: status write moves the selector only
        step(1'b1, 8'h01);
        idle();
        chk(out_on == 1'b1 && sense_en == 1'b1, "R9", out_on, 1);
        idle();
        chk(rd_byte == 8'h13, "R10", rd_byte, 8'h13);
        // R10: select timing, then write it: readback shows new value
        step(1'b1, 8'h03);
        step(1'b1, 8'h3D);
        idle();
        idle();
        chk(rd_byte == 8'h3D, "R10", rd_byte, 8'h3D);
        // R11: unused addresses change nothing
        step(1'b1, 8'hD0);
        step(1'b1, 8'h6F);
        step(1'b1, 8'h7F);
        idle();
        chk(blank_code == 2'd1 && openload_dis && oclo_timeout_dis && out_on,
            "R11", {openload_dis, oclo_timeout_dis, blank_code}, 13);
        // R8: only bit 1 of the direct-input word counts
        step(1'b1, 8'h4D);
        idle();
        chk(direct_in_block == 1'b0, "R8", direct_in_block, 0);
        step(1'b1, 8'h42);
        idle();
        chk(direct_in_block == 1'b1, "R8", direct_in_block, 1);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] w;
            w = 8'($urandom);
            if ($urandom_range(0, 3) == 0) w[6:4] = 3'd1;
            step(1'($urandom_range(0, 2) != 0), w);
        end
        idle();
        idle();
        // R1: reset in mid-operation clears again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(rd_byte == 8'h00 && out_on == 1'b0 && direct_in_block == 1'b0, "R1", rd_byte, 0);
        idle();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule